// File: doc/BRIEF.md
# Banked Gather/Scatter Conflict Scheduler

This block carries out one vector memory operation at a time on behalf of a SIMD datapath. An operation is either a gather, which reads one word per lane, or a scatter, which writes one word per lane. Each operation brings a per-lane word address, a lane mask and, for scatters, per-lane write data. The storage is a set of single-port banks. Each bank is split into sub-banks, and each sub-bank holds its own register array. Lanes that name the same word are folded into a single access. The remaining distinct requests are placed in a short queue in front of the sub-bank they target. Every sub-bank then serves the head of its queue each cycle, independently of the others.

Because the queues are deeper than one operation's typical load, a new operation can be admitted while earlier ones are still draining. Accesses from successive gathers or successive scatters therefore overlap in time. When all of an operation's accesses have been served, the block raises a one-cycle completion pulse. With the pulse it gives the gathered vector and the operation's conflict figure: the largest number of distinct words any one sub-bank had to serve for that operation. This figure is also the number of service cycles the operation needs when the queues start out empty.

Top module: `gsx_sched`

## Requirements
- R1: The low log2(BANKS) bits of a word address select the bank and the next bit selects the sub-bank; together these low bits form the sub-bank index (0 to 7 by default), and the remaining upper bits select the word inside that sub-bank.
- R2: Requests that target different sub-banks are served in the same cycle: an operation with at most one distinct word per sub-bank has a conflict figure of 1 and completes exactly as fast as a single-lane operation.
- R3: Active lanes of one operation that name the same address cause a single access; on a gather every one of those lanes receives the word that was read.
- R4: The conflict figure reported on out_conf is the maximum, over all sub-banks, of the number of distinct active addresses mapped there. An operation accepted at clock edge N while all queues are empty raises out_done after edge N+K+1, where K is its conflict figure.
- R5: When several active lanes of one scatter name the same address, the word stored is the data of the highest-numbered of those lanes.
- R6: Lanes whose mask bit is 0 make no access: a masked scatter lane leaves memory unchanged, and a masked gather lane returns zero. An operation with no active lanes completes with a conflict figure of 0.
- R7: in_ready is low while the next operation slot is still in use, or while any sub-bank queue lacks room for all of the presented operation's requests to it. An operation is accepted on a rising edge where in_valid and in_ready are both high.
- R8: Each sub-bank queue serves older operations before newer ones, so a gather sees every scatter accepted before it. Completions are reported in acceptance order.
- R9: With room in the queues and a free slot, an operation presented in the cycle after an acceptance is accepted without a stall, while the earlier one is still in progress.
- R10: out_kind on completion repeats the operation's kind (0 = gather, 1 = scatter); a scatter completes with out_data all zero.
- R11: While rst is high and after its release, out_done is low and in_ready is high for an operation with no active lanes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | The presented operation can be accepted |
| in_kind | input | 1 | 0 = gather, 1 = scatter |
| in_mask | input | LANES | Per-lane active bit |
| in_addr | input | LANES*AW | Per-lane word address |
| in_wdata | input | LANES*DW | Per-lane scatter data |
| out_done | output | 1 | One-cycle completion pulse |
| out_kind | output | 1 | Kind of the completed operation |
| out_data | output | LANES*DW | Gathered vector; zero in masked lanes and for scatters |
| out_conf | output | clog2(LANES+1) | Conflict figure of the completed operation |

## Verification
The assertions assume two things about the input. First, no presented operation carries more distinct words for a single sub-bank than a queue can hold, because such an operation could never be admitted. Second, in_valid and its payload stay unchanged while in_ready is low. The stimulus meets both. Every directed operation is sized to fit. Every random operation is drawn again until its busiest sub-bank has at most the queue depth. The sending task holds its inputs until it sees acceptance. The memory is filled by scatters before any gather reads it, so every expected word is defined.

// File: rtl/gsx_pkg.sv
package gsx_pkg;
  typedef enum logic {
    GSX_GATHER  = 1'b0,
    GSX_SCATTER = 1'b1
  } gsx_kind_e;
endpackage

// File: rtl/gsx_lane_merge.sv
// Folds lanes that share an address, picks the surviving scatter data and
// ranks the surviving requests inside each sub-bank in ascending lane order.
module gsx_lane_merge #(
  parameter int LANES = 16,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int SBW   = 3,
  parameter int CW    = 5
) (
  input  logic [LANES-1:0]                 mask,
  input  logic [LANES-1:0][AW-1:0]         addr,
  input  logic [LANES-1:0][DW-1:0]         wdata,
  output logic [LANES-1:0]                 lead,
  output logic [LANES-1:0][LANES-1:0]      grp,
  output logic [LANES-1:0][DW-1:0]         wlast,
  output logic [LANES-1:0][CW-1:0]         rank,
  output logic [(1<<SBW)-1:0][CW-1:0]      sbcnt,
  output logic [CW-1:0]                    maxc
);
  localparam int NSB = 1 << SBW;

  // lane i leads its address group when no lower active lane shares it
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lead[i]  = mask[i];
      grp[i]   = '0;
      wlast[i] = wdata[i];
      for (int j = 0; j < LANES; j++) begin
        if (mask[j] && addr[j] == addr[i]) begin
          grp[i][j] = 1'b1;
          if (j < i) lead[i] = 1'b0;
          else       wlast[i] = wdata[j];   // highest lane wins (R5)
        end
      end
    end
  end

  always_comb begin
    sbcnt = '0;
    maxc  = '0;
    for (int i = 0; i < LANES; i++) begin
      rank[i] = '0;
      for (int j = 0; j < i; j++)
        if (lead[j] && addr[j][SBW-1:0] == addr[i][SBW-1:0])
          rank[i] = rank[i] + CW'(1);
    end
    for (int i = 0; i < LANES; i++)
      if (lead[i]) sbcnt[addr[i][SBW-1:0]] = sbcnt[addr[i][SBW-1:0]] + CW'(1);
    for (int s = 0; s < NSB; s++)
      if (sbcnt[s] > maxc) maxc = sbcnt[s];
  end
endmodule

// File: rtl/gsx_subbank.sv
// One sub-bank: a multi-push request ring and a single-port word array.
module gsx_subbank #(
  parameter int LANES = 16,
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int SBW   = 3,
  parameter int IDX   = 0,
  parameter int QD    = 4,
  parameter int SW    = 1,
  parameter int CW    = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  logic                          push_wr,
  input  logic [SW-1:0]                 push_tag,
  input  logic [CW-1:0]                 push_n,
  input  logic [LANES-1:0]              lead,
  input  logic [LANES-1:0][AW-1:0]      addr,
  input  logic [LANES-1:0][LANES-1:0]   grp,
  input  logic [LANES-1:0][DW-1:0]      wlast,
  input  logic [LANES-1:0][CW-1:0]      rank,
  output logic [$clog2(QD+1)-1:0]       level,
  output logic                          pop_v,
  output logic                          pop_rd,
  output logic [SW-1:0]                 pop_tag,
  output logic [LANES-1:0]              pop_grp,
  output logic [DW-1:0]                 pop_data
);
  localparam int WW  = AW - SBW;
  localparam int QPW = $clog2(QD);
  localparam int QCW = $clog2(QD + 1);
  localparam int MW  = 1 << WW;

  logic [WW-1:0]    q_word [QD];
  logic [DW-1:0]    q_dat  [QD];
  logic [LANES-1:0] q_grp  [QD];
  logic             q_wr   [QD];
  logic [SW-1:0]    q_tag  [QD];
  logic [DW-1:0]    mem    [MW];
  logic [QPW-1:0]   wp, rp;

  assign pop_v    = (level != '0);
  assign pop_rd   = !q_wr[rp];
  assign pop_tag  = q_tag[rp];
  assign pop_grp  = q_grp[rp];
  assign pop_data = mem[q_word[rp]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push)  wp <= wp + QPW'(push_n);
      if (pop_v) rp <= rp + 1'b1;
      level <= level + (push ? QCW'(push_n) : '0) - (pop_v ? QCW'(1) : '0);
    end
  end

  // ring slots and word array carry no reset
  always_ff @(posedge clk) begin
    if (push) begin
      for (int i = 0; i < LANES; i++) begin
        if (lead[i] && addr[i][SBW-1:0] == SBW'(IDX)) begin
          q_word[wp + QPW'(rank[i])] <= addr[i][AW-1:SBW];
          q_dat [wp + QPW'(rank[i])] <= wlast[i];
          q_grp [wp + QPW'(rank[i])] <= grp[i];
          q_wr  [wp + QPW'(rank[i])] <= push_wr;
          q_tag [wp + QPW'(rank[i])] <= push_tag;
        end
      end
    end
    if (pop_v && q_wr[rp]) mem[q_word[rp]] <= q_dat[rp];
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(level) + int'(push_n) <= QD)); // R7
endmodule

// File: rtl/gsx_sched.sv
module gsx_sched
  import gsx_pkg::*;
#(
  parameter int LANES = 16,
  parameter int BANKS = 4,
  parameter int SUBS  = 2,
  parameter int QD    = 4,
  parameter int OPS   = 2,
  parameter int AW    = 8,
  parameter int DW    = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_kind,
  input  logic [LANES-1:0]             in_mask,
  input  logic [LANES-1:0][AW-1:0]     in_addr,
  input  logic [LANES-1:0][DW-1:0]     in_wdata,
  output logic                         out_done,
  output logic                         out_kind,
  output logic [LANES-1:0][DW-1:0]     out_data,
  output logic [$clog2(LANES+1)-1:0]   out_conf
);
  localparam int SBW = $clog2(BANKS) + $clog2(SUBS);
  localparam int NSB = BANKS * SUBS;
  localparam int CW  = $clog2(LANES + 1);
  localparam int SW  = (OPS > 1) ? $clog2(OPS) : 1;
  localparam int QCW = $clog2(QD + 1);

  logic [LANES-1:0]            m_lead;
  logic [LANES-1:0][LANES-1:0] m_grp;
  logic [LANES-1:0][DW-1:0]    m_wlast;
  logic [LANES-1:0][CW-1:0]    m_rank;
  logic [NSB-1:0][CW-1:0]      m_cnt;
  logic [CW-1:0]               m_max;

  gsx_lane_merge #(.LANES(LANES), .AW(AW), .DW(DW), .SBW(SBW), .CW(CW)) u_merge (
    .mask(in_mask), .addr(in_addr), .wdata(in_wdata), .lead(m_lead), .grp(m_grp),
    .wlast(m_wlast), .rank(m_rank), .sbcnt(m_cnt), .maxc(m_max));

  logic [QCW-1:0]   sb_level [NSB];
  logic [NSB-1:0]   pop_v, pop_rd;
  logic [SW-1:0]    pop_tag  [NSB];
  logic [LANES-1:0] pop_grp  [NSB];
  logic [DW-1:0]    pop_data [NSB];

  logic                        acc;
  logic [SW-1:0]               wslot, rslot;
  logic [OPS-1:0]              s_act;
  logic                        s_kind [OPS];
  logic [CW-1:0]               s_rem  [OPS];
  logic [CW-1:0]               s_conf [OPS];
  logic [LANES-1:0][DW-1:0]    s_res  [OPS];
  logic [CW-1:0]               dec    [OPS];
  logic                        fits;

  for (genvar s = 0; s < NSB; s++) begin : g_sb
    gsx_subbank #(.LANES(LANES), .AW(AW), .DW(DW), .SBW(SBW), .IDX(s), .QD(QD),
                  .SW(SW), .CW(CW)) u_sb (
      .clk(clk), .rst(rst), .push(acc), .push_wr(in_kind), .push_tag(wslot),
      .push_n(m_cnt[s]), .lead(m_lead), .addr(in_addr), .grp(m_grp), .wlast(m_wlast),
      .rank(m_rank), .level(sb_level[s]), .pop_v(pop_v[s]), .pop_rd(pop_rd[s]),
      .pop_tag(pop_tag[s]), .pop_grp(pop_grp[s]), .pop_data(pop_data[s]));

    AST_POP_LIVE: assert property (@(posedge clk) disable iff (rst)
      pop_v[s] |-> s_act[pop_tag[s]]); // R8
  end

  always_comb begin
    fits = 1'b1;
    for (int s = 0; s < NSB; s++)
      if (int'(sb_level[s]) + int'(m_cnt[s]) > QD) fits = 1'b0;
  end

  always_comb begin
    for (int k = 0; k < OPS; k++) begin
      dec[k] = '0;
      for (int s = 0; s < NSB; s++)
        if (pop_v[s] && pop_tag[s] == SW'(k)) dec[k] = dec[k] + CW'(1);
    end
  end

  assign in_ready = fits && !s_act[wslot];
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_act    <= '0;
      wslot    <= '0;
      rslot    <= '0;
      out_done <= 1'b0;
      out_kind <= 1'b0;
      out_data <= '0;
      out_conf <= '0;
    end else begin
      out_done <= 1'b0;
      for (int k = 0; k < OPS; k++)
        if (s_act[k]) s_rem[k] <= s_rem[k] - dec[k];
      for (int s = 0; s < NSB; s++)
        if (pop_v[s] && pop_rd[s])
          for (int l = 0; l < LANES; l++)
            if (pop_grp[s][l]) s_res[pop_tag[s]][l] <= pop_data[s];
      if (s_act[rslot] && s_rem[rslot] == '0) begin
        out_done     <= 1'b1;
        out_kind     <= s_kind[rslot];
        out_data     <= (s_kind[rslot] == GSX_GATHER) ? s_res[rslot] : '0;
        out_conf     <= s_conf[rslot];
        s_act[rslot] <= 1'b0;
        rslot        <= (rslot == SW'(OPS - 1)) ? '0 : rslot + 1'b1;
      end
      if (acc) begin
        s_act[wslot]  <= 1'b1;
        s_kind[wslot] <= in_kind;
        s_rem[wslot]  <= CW'($countones(m_lead));
        s_conf[wslot] <= m_max;
        s_res[wslot]  <= '0;
        wslot         <= (wslot == SW'(OPS - 1)) ? '0 : wslot + 1'b1;
      end
    end
  end

  AST_OP_FITS: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> int'(m_max) <= QD); // R7
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_ready |=> in_valid); // R7
  AST_SCATTER_ZERO: assert property (@(posedge clk) disable iff (rst)
    out_done && out_kind == GSX_SCATTER |-> out_data == '0); // R10
  AST_CONF_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_done |-> int'(out_conf) <= QD); // R4
endmodule

// File: tb/tb_gsx_sched.sv
`timescale 1ns/1ps
module tb_gsx_sched;
  localparam int L = 16, AW = 8, DW = 16, QD = 4, NSB = 8, SBW = 3, CW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, in_valid, in_ready, in_kind, out_done, out_kind;
  logic [L-1:0] in_mask;
  logic [L-1:0][AW-1:0] in_addr;
  logic [L-1:0][DW-1:0] in_wdata, out_data;
  logic [CW-1:0] out_conf;

  gsx_sched #(.LANES(L), .BANKS(4), .SUBS(2), .QD(QD), .OPS(2), .AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_mask(in_mask), .in_addr(in_addr), .in_wdata(in_wdata), .out_done(out_done),
    .out_kind(out_kind), .out_data(out_data), .out_conf(out_conf));

  int errs = 0, checks = 0, cyc = 0, stall_n = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [DW-1:0] mm [1<<AW];
  int q_kind[$], q_conf[$], q_cyc[$];
  string q_tag[$];
  logic [L-1:0][DW-1:0] q_data[$];

  logic [L-1:0] t_mask;
  logic [L-1:0][AW-1:0] t_addr;
  logic [L-1:0][DW-1:0] t_data;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // distinct addresses on the busiest sub-bank
  function automatic int calc_k();
    int best = 0;
    for (int s = 0; s < NSB; s++) begin
      int c = 0;
      for (int i = 0; i < L; i++) begin
        bit dup = 0;
        if (t_mask[i] && int'(t_addr[i][SBW-1:0]) == s) begin
          for (int j = 0; j < i; j++)
            if (t_mask[j] && t_addr[j] == t_addr[i]) dup = 1;
          if (!dup) c++;
        end
      end
      if (c > best) best = c;
    end
    return best;
  endfunction

  task automatic send(input bit kind, input bit iso, input string tag);
    logic [L-1:0][DW-1:0] e;
    int k;
    @(negedge clk);
    in_kind = kind; in_mask = t_mask; in_addr = t_addr; in_wdata = t_data; in_valid = 1'b1;
    stall_n = 0;
    #1;
    while (!in_ready) begin
      stall_n++;
      @(negedge clk);
      #1;
    end
    k = calc_k();
    for (int i = 0; i < L; i++)
      e[i] = (!kind && t_mask[i]) ? mm[t_addr[i]] : '0;
    if (kind)
      for (int i = 0; i < L; i++)
        if (t_mask[i]) mm[t_addr[i]] = t_data[i];
    q_kind.push_back(int'(kind)); q_conf.push_back(k); q_tag.push_back(tag);
    q_data.push_back(e); q_cyc.push_back(iso ? cyc + k + 2 : -1);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (q_kind.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clear_op();
    t_mask = '0; t_addr = '0; t_data = '0;
  endtask

  // reference comparison on every clock
  int ek, ec, ey, bad;
  string et;
  logic [L-1:0][DW-1:0] ed;
  always @(negedge clk) begin
    if (!rst && out_done) begin
      if (q_kind.size() == 0) chk(1'b0, "R8", "completion with nothing pending", 1, 0);
      else begin
        ek = q_kind.pop_front(); ec = q_conf.pop_front(); ey = q_cyc.pop_front();
        et = q_tag.pop_front(); ed = q_data.pop_front();
        chk(int'(out_kind) == ek, "R10", "kind", out_kind, ek);
        chk(int'(out_conf) == ec, "R4", "conflict figure", out_conf, ec);
        bad = -1;
        for (int l = 0; l < L; l++)
          if (out_data[l] !== ed[l] && bad < 0) bad = l;
        chk(bad < 0, et, $sformatf("lane %0d data", bad),
            (bad < 0) ? 64'd0 : 64'(out_data[bad]), (bad < 0) ? 64'd0 : 64'(ed[bad]));
        if (ey >= 0) chk(cyc == ey, et, "completion cycle", cyc, ey);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_kind = 1'b0; in_mask = '0; in_addr = '0; in_wdata = '0;
    clear_op();
    @(negedge clk);
    chk(out_done == 1'b0, "R11", "done during reset", out_done, 0);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(out_done == 1'b0, "R11", "done after reset", out_done, 0);
    chk(in_ready == 1'b1, "R11", "ready after reset", in_ready, 1);

    // fill memory with scatters, back to back (R9)
    for (int b = 0; b < 16; b++) begin
      t_mask = '1;
      for (int i = 0; i < L; i++) begin
        t_addr[i] = AW'(b * 16 + i);
        t_data[i] = DW'((b * 16 + i) * 37 + 5);
      end
      send(1'b1, 1'b0, "R8");
      if (b == 1) chk(stall_n == 0, "R9", "second op stalled", stall_n, 0);
    end
    wait_idle();

    // R2: one word on each sub-bank
    clear_op();
    for (int i = 0; i < 8; i++) begin t_mask[i] = 1'b1; t_addr[i] = AW'(9 * i); end
    send(1'b0, 1'b1, "R2");
    wait_idle();

    // R1: addresses 0 and 4 differ only in the sub-bank bit
    clear_op();
    t_mask[1:0] = 2'b11; t_addr[0] = 8'd0; t_addr[1] = 8'd4;
    send(1'b0, 1'b1, "R1");
    wait_idle();
    // R1: addresses 0 and 8 share a sub-bank
    t_addr[1] = 8'd8;
    send(1'b0, 1'b1, "R1");
    wait_idle();

    // R3: all lanes on one word
    clear_op();
    t_mask = '1;
    for (int i = 0; i < L; i++) t_addr[i] = 8'd37;
    send(1'b0, 1'b1, "R3");
    wait_idle();

    // R4: four words on sub-bank 0, singles elsewhere
    clear_op();
    t_mask = 16'h00FF;
    t_addr[0] = 8'd0; t_addr[1] = 8'd8; t_addr[2] = 8'd16; t_addr[3] = 8'd24;
    t_addr[4] = 8'd1; t_addr[5] = 8'd2; t_addr[6] = 8'd3; t_addr[7] = 8'd5;
    send(1'b0, 1'b1, "R4");
    wait_idle();

    // R5: duplicate scatter lanes, highest lane wins
    clear_op();
    t_mask[3] = 1'b1; t_mask[7] = 1'b1; t_mask[12] = 1'b1;
    t_addr[3] = 8'd50; t_addr[7] = 8'd50; t_addr[12] = 8'd50;
    t_data[3] = 16'h0111; t_data[7] = 16'h0222; t_data[12] = 16'h0333;
    send(1'b1, 1'b1, "R5");
    wait_idle();
    clear_op();
    t_mask[0] = 1'b1; t_addr[0] = 8'd50;
    send(1'b0, 1'b1, "R5");
    wait_idle();
    chk(mm[50] == 16'h0333, "R5", "model word 50", mm[50], 16'h0333);

    // R6: masked scatter lane must not write; masked gather lanes read zero
    clear_op();
    for (int i = 0; i < L; i++) begin t_addr[i] = AW'(100 + i); t_data[i] = 16'hBEEF; end
    t_mask = 16'hFFDF; t_addr[5] = 8'd60; t_data[5] = 16'hDEAD;
    send(1'b1, 1'b1, "R6");
    wait_idle();
    clear_op();
    t_mask = 16'hAAAA;
    for (int i = 0; i < L; i++) t_addr[i] = 8'd60;
    send(1'b0, 1'b1, "R6");
    wait_idle();
    clear_op();
    send(1'b0, 1'b1, "R6");
    wait_idle();

    // R8: gather right behind a scatter to the same word
    clear_op();
    t_mask[0] = 1'b1; t_addr[0] = 8'd70; t_data[0] = 16'h7070;
    send(1'b1, 1'b0, "R8");
    send(1'b0, 1'b0, "R8");
    wait_idle();

    // R7: second op needs room the first still occupies
    clear_op();
    t_mask = 16'h000F;
    t_addr[0] = 8'd0; t_addr[1] = 8'd8; t_addr[2] = 8'd16; t_addr[3] = 8'd24;
    t_data[0] = 16'h1; t_data[1] = 16'h2; t_data[2] = 16'h3; t_data[3] = 16'h4;
    send(1'b1, 1'b0, "R7");
    t_addr[0] = 8'd32; t_addr[1] = 8'd40; t_addr[2] = 8'd48; t_addr[3] = 8'd56;
    send(1'b0, 1'b0, "R7");
    chk(stall_n > 0, "R7", "full queue accepted at once", stall_n, 1);
    wait_idle();

    // R7 and R9: slot reuse with single-lane ops
    clear_op();
    t_mask[0] = 1'b1; t_addr[0] = 8'd1;
    send(1'b0, 1'b0, "R9");
    t_addr[0] = 8'd2;
    send(1'b0, 1'b0, "R9");
    chk(stall_n == 0, "R9", "overlap op stalled", stall_n, 0);
    t_addr[0] = 8'd3;
    send(1'b0, 1'b0, "R7");
    chk(stall_n > 0, "R7", "op accepted with no free slot", stall_n, 1);
    wait_idle();

    // random mixed traffic
    for (int n = 0; n < 300; n++) begin
      do begin
        t_mask = L'($urandom);
        for (int i = 0; i < L; i++) begin
          t_addr[i] = (n % 3 == 0) ? AW'($urandom_range(0, 15)) : AW'($urandom_range(0, 255));
          t_data[i] = DW'($urandom);
        end
      end while (calc_k() > QD);
      send(1'($urandom_range(0, 1)), 1'b0, "R8");
    end
    wait_idle();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule